// File: doc/BRIEF.md
# Flash Status and Write-Protect Controller

This block owns the eight-bit status byte of a small serial NOR flash. It also decides whether each modify request may run. An instruction decoder elsewhere presents one-cycle request strobes: enable writes, disable writes, status write with its data byte, page program, block erase and chip erase. Each request comes with its target address and the level of the active-low write-protect pin. A timing engine elsewhere pulses `cycleDone` when an internal cycle has finished.

For every request the block answers with a one-cycle grant or reject pulse. It returns the current status byte for read-out. It also pulses set or clear controls whenever its write-enable latch changes. The non-volatile bits are held in ordinary registers that reset to zero.

Protection works in layers:
- The write-enable latch must be set before any modify request is granted.
- Two block-protect bits fence off page program and block erase.
- Chip erase needs both block-protect bits clear.
- The status-lock bit, together with a low protect pin, freezes the status byte itself.

Top module: `nor_status_guard`

## Requirements
- R1: After reset the status byte is 00h and grant, reject, welSet and welClear are all 0.
- R2: The status byte is laid out as follows: bit 7 is the status-lock bit, bits 6..4 always read 0, bits 3..2 are the block-protect field, bit 1 is the write-enable latch (WEL) and bit 0 is BUSY.
- R3: A request sampled on a clock edge is answered on the outputs in the cycle that follows that edge. A write-enable request that is granted sets WEL and pulses welSet. A write-disable request that is granted clears WEL and pulses welClear.
- R4: Status write, page program, block erase and chip erase are rejected while WEL is 0.
- R5: A granted status write sets BUSY. On the next cycleDone, bits 7, 3 and 2 take the matching bits of the data byte. Data bits 6, 5, 4, 1 and 0 have no effect.
- R6: While the status-lock bit is 1 and wpN is low, a status write is rejected even when WEL is 1. With wpN high, or with the lock bit at 0, the pin has no effect.
- R7: If the block-protect field is nonzero, page program and block erase are rejected at every address in both blocks. If the field is 00, they are granted when WEL is 1.
- R8: Chip erase is granted only when the block-protect field is 00 and WEL is 1.
- R9: A cycleDone while BUSY is 1 clears BUSY and WEL and pulses welClear. A cycleDone while BUSY is 0 changes nothing.
- R10: While BUSY is 1, every request is rejected, including write-enable and write-disable.
- R11: Grant and reject are single-cycle pulses and never both 1. A rejected request leaves the status byte unchanged.
- R12: If several requests arrive together, only the first in the order write-enable, write-disable, status write, page program, block erase, chip erase is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqWren | input | 1 | Write-enable request strobe |
| reqWrdi | input | 1 | Write-disable request strobe |
| reqStatusWr | input | 1 | Status write request strobe |
| statusData | input | 8 | Data byte for a status write |
| reqProgram | input | 1 | Page program request strobe |
| reqBlockErase | input | 1 | Block erase request strobe |
| reqChipErase | input | 1 | Chip erase request strobe |
| targetAddr | input | ADDR_W | Byte address of a program or block erase |
| wpN | input | 1 | Write-protect pin level, active low |
| cycleDone | input | 1 | End of the running internal cycle |
| statusByte | output | 8 | Current status byte |
| grant | output | 1 | Request accepted pulse |
| reject | output | 1 | Request refused pulse |
| welSet | output | 1 | Write-enable latch set pulse |
| welClear | output | 1 | Write-enable latch clear pulse |

## Verification
Every internal state bit is also a bit of `statusByte`, except the pending status value. A wrong latch, protect or busy bit therefore shows up in the cycle after the edge that corrupted it. It also shows up one cycle later as a wrong grant or reject on the next request. A corrupted pending value stays hidden until the following `cycleDone`. The bench therefore always closes a status write with a completion and reads the byte back. Rejected requests are followed at once by a read-back of the status byte, so a reject that leaks a side effect is caught on the very next cycle.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int STATUS_W = 8;

  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_STWR, OP_PROG, OP_BERASE, OP_CERASE
  } opKind_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startBusy;
    logic endBusy;
    logic loadPend;
    logic grantP;
    logic rejectP;
  } ctrlStrobe_t;
endpackage

// File: rtl/nsg_control.sv
module nsg_control
  import nsg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLOCK_W = 1
) (
  input  logic              reqWren,
  input  logic              reqWrdi,
  input  logic              reqStatusWr,
  input  logic              reqProgram,
  input  logic              reqBlockErase,
  input  logic              reqChipErase,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              wpN,
  input  logic              cycleDone,
  input  logic              srwd,
  input  logic [1:0]        bp,
  input  logic              wel,
  input  logic              busy,
  output ctrlStrobe_t       strb
);
  localparam int NUM_BLOCKS = 1 << BLOCK_W;

  opKind_e op;
  logic [NUM_BLOCKS-1:0] protMap;
  logic [BLOCK_W-1:0] blockIdx;
  logic blkProt;
  logic hwLock;
  logic allowed;

  // Fixed priority among simultaneous requests
  always_comb begin
    if (reqWren)            op = OP_WREN;
    else if (reqWrdi)       op = OP_WRDI;
    else if (reqStatusWr)   op = OP_STWR;
    else if (reqProgram)    op = OP_PROG;
    else if (reqBlockErase) op = OP_BERASE;
    else if (reqChipErase)  op = OP_CERASE;
    else                    op = OP_NONE;
  end

  // Per-block protection: any nonzero protect field covers every block
  generate
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_prot
      assign protMap[b] = |bp;
    end
  endgenerate

  assign blockIdx = targetAddr[ADDR_W-1 -: BLOCK_W];
  assign blkProt  = protMap[blockIdx];
  assign hwLock   = srwd & ~wpN;

  always_comb begin
    case (op)
      OP_WREN, OP_WRDI:  allowed = 1'b1;
      OP_STWR:           allowed = wel & ~hwLock;
      OP_PROG, OP_BERASE: allowed = wel & ~blkProt;
      OP_CERASE:         allowed = wel & (bp == 2'b00);
      default:           allowed = 1'b0;
    endcase
  end

  always_comb begin
    strb           = '0;
    strb.endBusy   = cycleDone & busy;
    if (op != OP_NONE) begin
      if (!busy && allowed) strb.grantP = 1'b1;
      else                  strb.rejectP = 1'b1;
    end
    strb.setWel    = strb.grantP & (op == OP_WREN);
    strb.clrWel    = (strb.grantP & (op == OP_WRDI)) | strb.endBusy;
    strb.loadPend  = strb.grantP & (op == OP_STWR);
    strb.startBusy = strb.grantP & (op inside {OP_STWR, OP_PROG, OP_BERASE, OP_CERASE});
  end
endmodule

// File: rtl/nsg_datapath.sv
module nsg_datapath
  import nsg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [STATUS_W-1:0] statusData,
  output logic                srwd,
  output logic [1:0]          bp,
  output logic                wel,
  output logic                busy,
  output logic                grantQ,
  output logic                rejectQ,
  output logic                welSetQ,
  output logic                welClrQ
);
  logic       pendValid;
  logic [2:0] pendBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srwd      <= 1'b0;
      bp        <= 2'b00;
      wel       <= 1'b0;
      busy      <= 1'b0;
      pendValid <= 1'b0;
      pendBits  <= 3'b000;
      grantQ    <= 1'b0;
      rejectQ   <= 1'b0;
      welSetQ   <= 1'b0;
      welClrQ   <= 1'b0;
    end else begin
      grantQ  <= strb.grantP;
      rejectQ <= strb.rejectP;
      welSetQ <= strb.setWel;
      welClrQ <= strb.clrWel;
      if (strb.setWel)      wel <= 1'b1;
      else if (strb.clrWel) wel <= 1'b0;
      if (strb.startBusy)    busy <= 1'b1;
      else if (strb.endBusy) busy <= 1'b0;
      if (strb.loadPend) begin
        pendValid <= 1'b1;
        pendBits  <= {statusData[7], statusData[3], statusData[2]};
      end else if (strb.endBusy) begin
        pendValid <= 1'b0;
        if (pendValid) {srwd, bp} <= pendBits;
      end
    end
  end
endmodule

// File: rtl/nor_status_guard.sv
module nor_status_guard
  import nsg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLOCK_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWren,
  input  logic              reqWrdi,
  input  logic              reqStatusWr,
  input  logic [7:0]        statusData,
  input  logic              reqProgram,
  input  logic              reqBlockErase,
  input  logic              reqChipErase,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic              wpN,
  input  logic              cycleDone,
  output logic [7:0]        statusByte,
  output logic              grant,
  output logic              reject,
  output logic              welSet,
  output logic              welClear
);
  ctrlStrobe_t strb;
  logic srwd, wel, busy;
  logic [1:0] bp;

  nsg_control #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_ctrl (
    .reqWren(reqWren), .reqWrdi(reqWrdi), .reqStatusWr(reqStatusWr),
    .reqProgram(reqProgram), .reqBlockErase(reqBlockErase),
    .reqChipErase(reqChipErase), .targetAddr(targetAddr), .wpN(wpN),
    .cycleDone(cycleDone), .srwd(srwd), .bp(bp), .wel(wel), .busy(busy),
    .strb(strb)
  );

  nsg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .statusData(statusData),
    .srwd(srwd), .bp(bp), .wel(wel), .busy(busy),
    .grantQ(grant), .rejectQ(reject), .welSetQ(welSet), .welClrQ(welClear)
  );

  assign statusByte = {srwd, 3'b000, bp, wel, busy};
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker #(
  parameter int ADDR_W = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqWren,
  input logic       reqWrdi,
  input logic       reqStatusWr,
  input logic       reqProgram,
  input logic       reqBlockErase,
  input logic       reqChipErase,
  input logic       wpN,
  input logic       cycleDone,
  input logic [7:0] statusByte,
  input logic       grant,
  input logic       reject,
  input logic       welSet
);
  logic soloStWr, soloProg, soloCe;
  assign soloStWr = reqStatusWr & ~reqWren & ~reqWrdi;
  assign soloProg = reqProgram & ~reqWren & ~reqWrdi & ~reqStatusWr;
  assign soloCe   = reqChipErase & ~reqWren & ~reqWrdi & ~reqStatusWr
                  & ~reqProgram & ~reqBlockErase;

  AST_GRANT_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && reject)); // R11
  AST_REJECT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (reject && !$past(cycleDone)) |-> statusByte == $past(statusByte)); // R11
  AST_WEL_NEEDED: assert property (@(posedge clk) disable iff (!rstN)
    (soloProg && !statusByte[1]) |=> reject); // R4
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (soloStWr && statusByte[7] && !wpN) |=> !grant); // R6
  AST_CE_NEEDS_CLEAR_BP: assert property (@(posedge clk) disable iff (!rstN)
    (soloCe && statusByte[3:2] != 2'b00) |=> reject); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && statusByte[0]) |=> (!statusByte[0] && !statusByte[1])); // R9
  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqWren && statusByte[0]) |=> (reject && !welSet)); // R10
  AST_WELSET_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    welSet |-> statusByte[1]); // R3
endmodule

bind nor_status_guard nsg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqWren(reqWren), .reqWrdi(reqWrdi),
  .reqStatusWr(reqStatusWr), .reqProgram(reqProgram),
  .reqBlockErase(reqBlockErase), .reqChipErase(reqChipErase), .wpN(wpN),
  .cycleDone(cycleDone), .statusByte(statusByte), .grant(grant),
  .reject(reject), .welSet(welSet)
);

// File: tb/nor_status_guard_bench.sv
`timescale 1ns/1ps
module nor_status_guard_bench;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqWren = 0, reqWrdi = 0, reqStatusWr = 0, reqProgram = 0;
  logic reqBlockErase = 0, reqChipErase = 0, wpN = 1, cycleDone = 0;
  logic [7:0] statusData = 8'h00;
  logic [ADDR_W-1:0] targetAddr = '0;
  logic [7:0] statusByte;
  logic grant, reject, welSet, welClear;

  always #2 clk = ~clk;

  nor_status_guard #(.ADDR_W(ADDR_W)) u_nor_status_guard (
    .clk(clk), .rstN(rstN), .reqWren(reqWren), .reqWrdi(reqWrdi),
    .reqStatusWr(reqStatusWr), .statusData(statusData),
    .reqProgram(reqProgram), .reqBlockErase(reqBlockErase),
    .reqChipErase(reqChipErase), .targetAddr(targetAddr), .wpN(wpN),
    .cycleDone(cycleDone), .statusByte(statusByte), .grant(grant),
    .reject(reject), .welSet(welSet), .welClear(welClear)
  );

  typedef struct {
    logic g, r, ws, wc;
    logic [7:0] st;
    string tag;
  } expItem_t;

  expItem_t q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  // bench-side model of the status state
  logic mSrwd = 0, mWel = 0, mBusy = 0, mPendV = 0;
  logic [1:0] mBp = 0;
  logic [2:0] mPend = 0;

  // kind: 0 idle, 1 wren, 2 wrdi, 3 status write, 4 program,
  //       5 block erase, 6 chip erase, 7 wrdi together with chip erase
  task automatic step(input int kind, input logic [7:0] d,
                      input logic [ADDR_W-1:0] a, input logic wp,
                      input logic done, input string tag);
    expItem_t e;
    int op;
    @(negedge clk);
    reqWren = (kind == 1); reqWrdi = (kind == 2 || kind == 7);
    reqStatusWr = (kind == 3); reqProgram = (kind == 4);
    reqBlockErase = (kind == 5); reqChipErase = (kind == 6 || kind == 7);
    statusData = d; targetAddr = a; wpN = wp; cycleDone = done;
    op = (kind == 7) ? 2 : kind;
    e.g = 0; e.r = 0; e.ws = 0; e.wc = 0; e.tag = tag;
    if (op != 0) begin
      if (mBusy) e.r = 1;
      else begin
        case (op)
          1, 2: e.g = 1;
          3: e.g = mWel && !(mSrwd && !wp);
          default: e.g = mWel && (mBp == 2'b00);
        endcase
        e.r = !e.g;
      end
    end
    if (done && mBusy) begin
      mBusy = 0; mWel = 0; e.wc = 1;
      if (mPendV) begin {mSrwd, mBp} = mPend; mPendV = 0; end
    end
    if (e.g) begin
      case (op)
        1: begin mWel = 1; e.ws = 1; end
        2: begin mWel = 0; e.wc = 1; end
        3: begin mBusy = 1; mPendV = 1; mPend = {d[7], d[3], d[2]}; end
        default: mBusy = 1;
      endcase
    end
    e.st = {mSrwd, 3'b000, mBp, mWel, mBusy};
    q.push_back(e);
  endtask

  // monitor: compares one expectation per clock after the outputs settle
  always @(posedge clk) begin
    if (rstN) begin
      #1;
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        checks++;
        if (grant !== e.g || reject !== e.r || welSet !== e.ws ||
            welClear !== e.wc || statusByte !== e.st) begin
          fails++;
          $display("FAIL %s: got g=%b r=%b ws=%b wc=%b st=%h, expected g=%b r=%b ws=%b wc=%b st=%h",
                   e.tag, grant, reject, welSet, welClear, statusByte,
                   e.g, e.r, e.ws, e.wc, e.st);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    step(0, 0, 0, 1, 0, "R1 reset state");
    step(4, 0, 16'h0100, 1, 0, "R4 program without WEL");
    step(3, 8'h8C, 0, 1, 0, "R4 status write without WEL");
    step(6, 0, 0, 1, 0, "R4 chip erase without WEL");
    step(1, 0, 0, 1, 0, "R3 write enable");
    step(2, 0, 0, 1, 0, "R3 write disable");
    step(1, 0, 0, 1, 0, "R3 write enable again");
    step(3, 8'hFF, 0, 1, 0, "R5 status write grant");
    step(0, 0, 0, 1, 0, "R5 busy held");
    step(1, 0, 0, 1, 0, "R10 wren while busy");
    step(2, 0, 0, 1, 0, "R10 wrdi while busy");
    step(0, 0, 0, 1, 1, "R5 R2 status commit");
    step(0, 0, 0, 1, 1, "R9 done while idle");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(4, 0, 16'h0100, 1, 0, "R7 program low block protected");
    step(5, 0, 16'h9000, 1, 0, "R7 erase high block protected");
    step(6, 0, 0, 1, 0, "R8 chip erase with BP set");
    step(0, 0, 0, 1, 0, "R11 status unchanged after rejects");
    step(3, 8'h00, 0, 0, 0, "R6 locked status write");
    step(0, 0, 0, 0, 0, "R11 status after locked write");
    step(3, 8'h00, 0, 1, 0, "R6 unlock by pin");
    step(0, 0, 0, 1, 1, "R9 done clears busy and WEL");
    step(1, 0, 0, 0, 0, "R3 wren pin low");
    step(3, 8'h0C, 0, 0, 0, "R6 pin ignored when lock bit 0");
    step(0, 0, 0, 1, 1, "R5 commit BP=11");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(3, 8'h00, 0, 1, 0, "R5 clear BP");
    step(0, 0, 0, 1, 1, "R5 commit clear");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(4, 0, 16'h80F0, 1, 0, "R7 program granted high block");
    step(0, 0, 0, 1, 1, "R9 program done");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(5, 0, 16'h0005, 1, 0, "R7 erase granted low block");
    step(0, 0, 0, 1, 1, "R9 erase done");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(6, 0, 0, 1, 0, "R8 chip erase granted");
    step(0, 0, 0, 1, 1, "R9 chip erase done");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(3, 8'h04, 0, 1, 0, "R5 BP=01");
    step(0, 0, 0, 1, 1, "R5 commit BP=01");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(6, 0, 0, 1, 0, "R8 chip erase BP=01");
    step(4, 0, 16'h0010, 1, 0, "R7 program BP=01");
    step(7, 0, 0, 1, 0, "R12 wrdi beats chip erase");
    step(1, 0, 0, 1, 0, "R3 wren");
    step(3, 8'h73, 0, 1, 0, "R5 data bits ignored");
    step(0, 0, 0, 1, 1, "R5 R2 commit ignores other bits");
    step(0, 0, 0, 1, 0, "R11 idle tail");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule